// File: doc/BRIEF.md
# Mode-Switched Mini ALU

This block is a small processing unit driven by switches and push keys. It has three modes: arithmetic, comparison and bitwise logic. Two debounced keys form a two-level mode selector. The first key moves between arithmetic and a non-arithmetic group. The second key picks comparison or logic inside that group. A 2-bit operation select then chooses one of four operations in the current mode. Eight data switches supply the operands. The switches are wired in reverse, so the leftmost switch is the least significant bit. From them the block takes two 4-bit values, x and y, and one byte, z.

The result is held in a register. It drives two hexadecimal seven-segment digits with active-low segments. Two separate indicator outputs show a carry or borrow, and the bit shifted out by a halving. Inputs applied before a clock edge appear on the outputs after that edge. A key change takes one more edge, because the mode register updates first.

Top module: `mini_alu_top`

## Requirements
- R1: A synchronous active-high reset sets the mode to arithmetic and clears the result to 0x00. Both digits then show 0, and both flags are 0.
- R2: Operand mapping: x bit i equals sw[7-i] for i=0..3, y bit i equals sw[3-i] for i=0..3, and z bit i equals sw[7-i] for i=0..7. All three operands are unsigned.
- R3: A rising edge on key_grp toggles between arithmetic mode and the non-arithmetic group. Holding the key high causes no further toggles.
- R4: A rising edge on key_sub toggles between comparison and logic only while the non-arithmetic group is active. In arithmetic mode it is ignored. After reset, the group starts on comparison.
- R5: Arithmetic, op 0: the result is (x+y) mod 16, with the high digit 0. carry_led shows bit 4 of the sum.
- R6: Arithmetic, op 1: the result is (x-y) mod 16, with the high digit 0. carry_led is 1 when y > x.
- R7: Arithmetic, op 2: the result is z shifted left by one, as a byte. carry_led is z bit 7.
- R8: Arithmetic, op 3: the result is z shifted right by one. rem_led is z bit 0.
- R9: Logic mode: op 0 gives x AND y, op 1 gives x OR y and op 2 gives x XOR y, each in the low digit with the high digit 0. Op 3 gives NOT z as a full byte.
- R10: Comparison mode gives 1 or 0 in the low digit: op 0 for x==y, op 1 for x>y, op 2 for x<y. Op 3 gives max(x,y). The high digit is 0.
- R11: hex_seg[6:0] shows the low nibble and hex_seg[13:7] shows the high nibble. Each digit is in gfedcba order (bit 0 is segment a) and is active low. Digit patterns with 1 meaning lit: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71.
- R12: The result and both flags are registered and change one clock edge after their inputs. carry_led is 0 except in arithmetic ops 0 to 2. rem_led is 0 except in arithmetic op 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_grp | input | 1 | Debounced key: arithmetic vs. non-arithmetic group |
| key_sub | input | 1 | Debounced key: comparison vs. logic |
| op_sel | input | 2 | Operation select inside the current mode |
| sw | input | 8 | Data switches, reversed bit order |
| hex_seg | output | 14 | Two active-low seven-segment digits |
| carry_led | output | 1 | Carry / borrow indicator |
| rem_led | output | 1 | Shifted-out remainder indicator |

## Verification
The hardest case to reach from the ports is the second key arriving while arithmetic mode is active. Its effect can only be seen later, after the first key has moved into the non-arithmetic group. The bench therefore pulses key_sub in arithmetic mode, then switches group. It applies an input whose comparison result differs from its logic result, and the output shows which sub-mode is active. The bench also holds a key high for several cycles to show that only one toggle happens. It also checks that carry and borrow on the same 4-bit adder chain appear with the correct polarity.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int NDIG   = BYTE_W / NIB_W;
    localparam int SEG_W  = 7;

    typedef enum logic [1:0] {
        MODE_ARITH = 2'd0,
        MODE_CMP   = 2'd1,
        MODE_LOGIC = 2'd2
    } mode_e;

    // operation codes per mode
    localparam logic [1:0] OP_ADD = 2'd0;
    localparam logic [1:0] OP_SUB = 2'd1;
    localparam logic [1:0] OP_SHL = 2'd2;
    localparam logic [1:0] OP_SHR = 2'd3;

    localparam logic [1:0] OP_AND = 2'd0;
    localparam logic [1:0] OP_OR  = 2'd1;
    localparam logic [1:0] OP_XOR = 2'd2;
    localparam logic [1:0] OP_NOT = 2'd3;

    localparam logic [1:0] OP_EQ  = 2'd0;
    localparam logic [1:0] OP_GT  = 2'd1;
    localparam logic [1:0] OP_LT  = 2'd2;
    localparam logic [1:0] OP_MAX = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              carry;
        logic              rem;
    } unit_res_t;

    // nibble to active-low gfedcba pattern
    function automatic logic [SEG_W-1:0] nib_to_seg_n(input logic [NIB_W-1:0] v);
        logic [SEG_W-1:0] lit;
        case (v)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/alu_mode_ctrl.sv
module alu_mode_ctrl
    import mini_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_grp,
    input  logic  key_sub,
    output mode_e mode
);

    logic grp_q;   // 0: arithmetic, 1: non-arithmetic group
    logic sub_q;   // 0: comparison, 1: logic
    logic kg_q;
    logic ks_q;
    logic rise_g;
    logic rise_s;

    assign rise_g = key_grp & ~kg_q;
    assign rise_s = key_sub & ~ks_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= 1'b0;
            sub_q <= 1'b0;
            kg_q  <= 1'b0;
            ks_q  <= 1'b0;
        end else begin
            kg_q <= key_grp;
            ks_q <= key_sub;
            if (rise_g)
                grp_q <= ~grp_q;
            if (rise_s && grp_q)
                sub_q <= ~sub_q;
        end
    end

    always_comb begin
        if (!grp_q)
            mode = MODE_ARITH;
        else if (sub_q)
            mode = MODE_LOGIC;
        else
            mode = MODE_CMP;
    end

    AST_RESET_MODE: assert property (@(posedge clk)
        rst |=> (mode == MODE_ARITH)); // R1

    AST_GROUP_FLIP: assert property (@(posedge clk) disable iff (rst)
        (key_grp && !kg_q) |=> (grp_q != $past(grp_q))); // R3

    AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (key_grp && kg_q) |=> $stable(grp_q)); // R3

    AST_SUB_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (!grp_q) |=> $stable(sub_q)); // R4

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import mini_alu_pkg::*;
(
    input  logic [NIB_W-1:0]  x,
    input  logic [NIB_W-1:0]  y,
    input  logic [BYTE_W-1:0] z,
    input  logic [1:0]        op,
    output unit_res_t         res
);

    logic             do_sub;
    logic [NIB_W-1:0] b_in;
    logic [NIB_W:0]   c;
    logic [NIB_W-1:0] s;

    // shared ripple chain: subtraction adds ~y with carry-in 1
    assign do_sub = (op == OP_SUB);
    assign b_in   = do_sub ? ~y : y;
    assign c[0]   = do_sub;

    for (genvar i = 0; i < NIB_W; i++) begin : g_fa
        assign s[i]   = x[i] ^ b_in[i] ^ c[i];
        assign c[i+1] = (x[i] & b_in[i]) | (c[i] & (x[i] ^ b_in[i]));
    end

    always_comb begin
        res = '0;
        case (op)
            OP_ADD: begin
                res.data  = BYTE_W'(s);
                res.carry = c[NIB_W];
            end
            OP_SUB: begin
                res.data  = BYTE_W'(s);
                res.carry = ~c[NIB_W];
            end
            OP_SHL: begin
                res.data  = {z[BYTE_W-2:0], 1'b0};
                res.carry = z[BYTE_W-1];
            end
            default: begin
                res.data = {1'b0, z[BYTE_W-1:1]};
                res.rem  = z[0];
            end
        endcase
    end

    always_comb begin
        if (op == OP_ADD)
            AST_RIPPLE_SUM: assert ({res.carry, res.data[NIB_W-1:0]} ==
                                    ((NIB_W+1)'(x) + (NIB_W+1)'(y))); // R5
        if (op == OP_SUB)
            AST_BORROW: assert (res.carry == (y > x)); // R6
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import mini_alu_pkg::*;
(
    input  logic [NIB_W-1:0]  x,
    input  logic [NIB_W-1:0]  y,
    input  logic [BYTE_W-1:0] z,
    input  logic [1:0]        op,
    output unit_res_t         res
);

    always_comb begin
        res = '0;
        case (op)
            OP_AND:  res.data = BYTE_W'(x & y);
            OP_OR:   res.data = BYTE_W'(x | y);
            OP_XOR:  res.data = BYTE_W'(x ^ y);
            default: res.data = ~z;
        endcase
    end

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import mini_alu_pkg::*;
(
    input  logic [NIB_W-1:0] x,
    input  logic [NIB_W-1:0] y,
    input  logic [1:0]       op,
    output unit_res_t        res
);

    always_comb begin
        res = '0;
        case (op)
            OP_EQ:   res.data = BYTE_W'(x == y);
            OP_GT:   res.data = BYTE_W'(x > y);
            OP_LT:   res.data = BYTE_W'(x < y);
            default: res.data = BYTE_W'((x > y) ? x : y);
        endcase
    end

endmodule

// File: rtl/mini_alu_top.sv
module mini_alu_top
    import mini_alu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    key_grp,
    input  logic                    key_sub,
    input  logic [1:0]              op_sel,
    input  logic [BYTE_W-1:0]       sw,
    output logic [NDIG*SEG_W-1:0]   hex_seg,
    output logic                    carry_led,
    output logic                    rem_led
);

    mode_e             mode;
    logic [BYTE_W-1:0] z;
    logic [NIB_W-1:0]  x;
    logic [NIB_W-1:0]  y;
    unit_res_t         ar_res;
    unit_res_t         lg_res;
    unit_res_t         cp_res;
    unit_res_t         sel_res;
    logic [BYTE_W-1:0] res_q;
    logic              carry_q;
    logic              rem_q;

    // leftmost switch is the least significant bit
    for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
        assign z[i] = sw[BYTE_W-1-i];
    end
    assign x = z[NIB_W-1:0];
    assign y = z[BYTE_W-1:NIB_W];

    alu_mode_ctrl u_mode (
        .clk     (clk),
        .rst     (rst),
        .key_grp (key_grp),
        .key_sub (key_sub),
        .mode    (mode)
    );

    alu_arith_unit u_arith (.x(x), .y(y), .z(z), .op(op_sel), .res(ar_res));
    alu_logic_unit u_logic (.x(x), .y(y), .z(z), .op(op_sel), .res(lg_res));
    alu_cmp_unit   u_cmp   (.x(x), .y(y),        .op(op_sel), .res(cp_res));

    always_comb begin
        case (mode)
            MODE_ARITH: sel_res = ar_res;
            MODE_CMP:   sel_res = cp_res;
            MODE_LOGIC: sel_res = lg_res;
            default:    sel_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            carry_q <= 1'b0;
            rem_q   <= 1'b0;
        end else begin
            res_q   <= sel_res.data;
            carry_q <= sel_res.carry;
            rem_q   <= sel_res.rem;
        end
    end

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        assign hex_seg[d*SEG_W +: SEG_W] = nib_to_seg_n(res_q[d*NIB_W +: NIB_W]);
    end

    assign carry_led = carry_q;
    assign rem_led   = rem_q;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(carry_led && rem_led)); // R12

    AST_REM_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rem_q |-> ($past(mode) == MODE_ARITH && $past(op_sel) == OP_SHR)); // R12

    AST_CARRY_SOURCE: assert property (@(posedge clk) disable iff (rst)
        carry_q |-> ($past(mode) == MODE_ARITH && $past(op_sel) != OP_SHR)); // R12

    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_CMP && $past(op_sel) != OP_MAX) |-> (res_q <= 1)); // R10

endmodule

// File: tb/sim_mini_alu_top.sv
module sim_mini_alu_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_grp = 1'b0;
    logic        key_sub = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic [7:0]  sw = 8'h00;
    logic [13:0] hex_seg;
    logic        carry_led;
    logic        rem_led;

    int n_checks = 0;
    int n_fail   = 0;
    bit grp_m = 1'b0;  // bench model of the mode selector
    bit sub_m = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mini_alu_top u0 (
        .clk       (clk),
        .rst       (rst),
        .key_grp   (key_grp),
        .key_sub   (key_sub),
        .op_sel    (op_sel),
        .sw        (sw),
        .hex_seg   (hex_seg),
        .carry_led (carry_led),
        .rem_led   (rem_led)
    );

    // vector: mode(2) op(2) z(8) result(8) carry(1) rem(1); mode 0 arith, 1 cmp, 2 logic
    localparam int NV = 19;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'h53, 8'h08, 1'b0, 1'b0},  // R5 3+5
        {2'd0, 2'd0, 8'h9F, 8'h08, 1'b1, 1'b0},  // R5 F+9 carry
        {2'd0, 2'd1, 8'h25, 8'h03, 1'b0, 1'b0},  // R6 5-2
        {2'd0, 2'd1, 8'h52, 8'h0D, 1'b1, 1'b0},  // R6 2-5 borrow
        {2'd0, 2'd1, 8'h77, 8'h00, 1'b0, 1'b0},  // R6 equal
        {2'd0, 2'd2, 8'hA7, 8'h4E, 1'b1, 1'b0},  // R7
        {2'd0, 2'd2, 8'h35, 8'h6A, 1'b0, 1'b0},  // R7
        {2'd0, 2'd3, 8'hA7, 8'h53, 1'b0, 1'b1},  // R8
        {2'd0, 2'd3, 8'h40, 8'h20, 1'b0, 1'b0},  // R8
        {2'd2, 2'd0, 8'hC6, 8'h04, 1'b0, 1'b0},  // R9 and
        {2'd2, 2'd1, 8'hC6, 8'h0E, 1'b0, 1'b0},  // R9 or
        {2'd2, 2'd2, 8'hC6, 8'h0A, 1'b0, 1'b0},  // R9 xor
        {2'd2, 2'd3, 8'hC6, 8'h39, 1'b0, 1'b0},  // R9 not
        {2'd1, 2'd0, 8'h77, 8'h01, 1'b0, 1'b0},  // R10 eq
        {2'd1, 2'd0, 8'h76, 8'h00, 1'b0, 1'b0},  // R10 ne
        {2'd1, 2'd1, 8'h29, 8'h01, 1'b0, 1'b0},  // R10 gt
        {2'd1, 2'd1, 8'h92, 8'h00, 1'b0, 1'b0},  // R10 not gt
        {2'd1, 2'd2, 8'h92, 8'h01, 1'b0, 1'b0},  // R10 lt
        {2'd1, 2'd3, 8'h3B, 8'h0B, 1'b0, 1'b0}   // R10 max
    };

    function automatic logic [6:0] seg_of(input logic [3:0] v);  // R11 table
        logic [6:0] p;
        case (v)
            4'h0: p = 7'h3F; 4'h1: p = 7'h06; 4'h2: p = 7'h5B; 4'h3: p = 7'h4F;
            4'h4: p = 7'h66; 4'h5: p = 7'h6D; 4'h6: p = 7'h7D; 4'h7: p = 7'h07;
            4'h8: p = 7'h7F; 4'h9: p = 7'h6F; 4'hA: p = 7'h77; 4'hB: p = 7'h7C;
            4'hC: p = 7'h39; 4'hD: p = 7'h5E; 4'hE: p = 7'h79; default: p = 7'h71;
        endcase
        return ~p;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);  // R2 mapping
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic [1:0] o);
        if (m == 2'd1) return "R10";
        if (m == 2'd2) return "R9";
        case (o)
            2'd0: return "R5";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] exp_res,
                         input logic exp_c, input logic exp_r);
        logic [13:0] exp_seg;
        exp_seg = {seg_of(exp_res[7:4]), seg_of(exp_res[3:0])};
        n_checks++;
        if (hex_seg !== exp_seg || carry_led !== exp_c || rem_led !== exp_r) begin
            n_fail++;
            $display("FAIL %s: seg=%h c=%b r=%b expected seg=%h c=%b r=%b",
                     tag, hex_seg, carry_led, rem_led, exp_seg, exp_c, exp_r);
        end
    endtask

    task automatic pulse(input bit which_sub);
        @(negedge clk);
        if (which_sub) key_sub = 1'b1; else key_grp = 1'b1;
        @(negedge clk);
        key_sub = 1'b0;
        key_grp = 1'b0;
        if (!which_sub) grp_m = ~grp_m;
        else if (grp_m) sub_m = ~sub_m;
    endtask

    task automatic go_mode(input logic [1:0] m);
        if (m == 2'd0) begin
            if (grp_m) pulse(1'b0);
        end else begin
            if (!grp_m) pulse(1'b0);
            if (sub_m != (m == 2'd2)) pulse(1'b1);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] z);
        @(negedge clk);
        op_sel = op;
        sw = rev8(z);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state, checked before release
        check("R1 reset", 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1/R11 after release", 8'h00, 1'b0, 1'b0);

        // R12: one-cycle latency - sample after a single edge
        @(negedge clk);
        op_sel = 2'd3;
        sw = rev8(8'hA7);
        check("R12 before edge", 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R12 after one edge", 8'h53, 1'b0, 1'b1);

        // vector walk (R2 through R11)
        for (int k = 0; k < NV; k++) begin
            go_mode(VEC[k][21:20]);
            apply(VEC[k][19:18], VEC[k][17:10]);
            check(tag_of(VEC[k][21:20], VEC[k][19:18]), VEC[k][9:2], VEC[k][1], VEC[k][0]);
        end

        // R4: second key ignored in arithmetic mode
        go_mode(2'd0);
        pulse(1'b1);            // model keeps sub_m since grp_m == 0
        pulse(1'b0);            // enter group: must be comparison
        apply(2'd0, 8'h77);     // eq -> 1; logic AND would give 7
        check("R4 sub key ignored in arith", 8'h01, 1'b0, 1'b0);

        // R3: holding first key high toggles once
        @(negedge clk);
        key_grp = 1'b1;
        repeat (5) @(negedge clk);
        key_grp = 1'b0;
        grp_m = 1'b0;
        apply(2'd0, 8'h77);     // arith add 7+7 = E
        check("R3 held key single toggle", 8'h0E, 1'b0, 1'b0);

        // R12: flags clear in non-arithmetic modes with all-ones operands
        go_mode(2'd2);
        apply(2'd1, 8'hFF);
        check("R12 no flags in logic", 8'h0F, 1'b0, 1'b0);

        // R1: mid-run reset returns to arithmetic
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        grp_m = 1'b0;
        sub_m = 1'b0;
        apply(2'd2, 8'h81);     // shl: 02, carry 1
        check("R1/R7 arith after reset", 8'h02, 1'b1, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule